// File: doc/BRIEF.md
# Multichannel Edge Time-Stamping Counter

This block records the arrival time of every rising edge on several independent, already squared-up digital inputs, such as zero-crossing detector outputs or pulse trains. All inputs are measured against one free-running timebase counter that advances once per reference clock cycle. With a 10 MHz reference, one count is 100 ns. Each input cycle gets its own timestamp, so the period of every single cycle can be recovered downstream. This differs from a gated frequency counter, which only gives an average over its gate interval.

Each channel has its own decimation count N. It can report every rising edge, or only every Nth one, for example one in sixty when logging a mains input. Reported timestamps can be coarser than the counter, with a parameter setting how many low bits are cleared.

Timestamps wait in a small queue per channel. The queues are merged by a round-robin arbiter into one valid/ready output stream, and each entry is tagged with the index of its channel. A queue that fills drops new arrivals and raises a sticky overflow flag for that channel.

Top module: `ets_top`

## Requirements
- R1: The timebase counter is 0 after reset and increases by one on every clock edge while reset is low, wrapping modulo 2^TS_W.
- R2: Each input passes through a two-flop synchronizer and a rising-edge detector. If the input is first seen high at clock edge k, its timestamp is the timebase value that holds between edges k+1 and k+2, that is, the value at edge k plus 2.
- R3: Only low-to-high transitions count. A falling edge, and an input that stays high for many cycles, add no entries.
- R4: The field for channel c in `div_n` (bits c*DIV_W upward) holds its decimation count N. The channel reports its Nth, 2Nth, 3Nth... rising edges. N of 0 or 1 reports every rising edge.
- R5: The low GRAN_SHIFT bits of every reported timestamp are zero. The upper bits equal the captured timebase value.
- R6: Entries of one channel leave in capture order. `out_chan` carries the channel index, which is always below NCH.
- R7: Requests are served in round-robin order. After reset, channel 0 has the highest priority. After channel c is granted, the search starts at channel c+1 and wraps past NCH-1 to 0.
- R8: A timestamp that arrives while its channel queue is full is dropped, and that channel's `ovf` bit is set. The bit stays set until reset. With `out_ready` low and one channel active, DEPTH+1 entries are held (DEPTH in the queue and one in the output register).
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_chan` and `out_ts` hold their values.
- R10: In the first cycle after reset, `out_valid` is low and all `ovf` bits are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; each cycle is one timebase count |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | NCH | Asynchronous squared-up inputs, one per channel |
| div_n | input | NCH*DIV_W | Decimation count per channel, channel c at bits c*DIV_W upward |
| out_valid | output | 1 | Output entry valid |
| out_ready | input | 1 | Consumer accepts the entry this cycle |
| out_chan | output | max(1,clog2(NCH)) | Channel index of the entry |
| out_ts | output | TS_W | Quantized timestamp |
| ovf | output | NCH | Sticky per-channel overflow flags |

## Verification
The bench builds the block with NCH=3, TS_W=16, GRAN_SHIFT=2, DEPTH=4 and DIV_W=6. Three channels are enough to tell rotating priority apart from fixed priority. A four-deep queue can be filled in a few pulses, which brings the drop and sticky-flag path within reach. With a shift of 2, quantization clears two bits, so expected timestamps that are not multiples of four would expose a wrong mask. Decimation counts of 3, 1 and 0 on the three channels exercise the skipping path and both forms of pass-through together. Output stalls during the vector walk test the hold rule while entries from several channels are waiting.

// File: rtl/ets_pkg.sv
package ets_pkg;
  // Next round-robin start index after granting idx, wrapping at n.
  function automatic int unsigned rr_next(input int unsigned idx, input int unsigned n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction
endpackage

// File: rtl/ets_fifo.sv
module ets_fifo #(
  parameter int W     = 40,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;

  assign empty = (wp == rp);
  assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign head  = mem[rp[AW-1:0]];

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push && !full) mem[wp[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push && !full) wp <= wp + 1'b1;
      if (pop && !empty) rp <= rp + 1'b1;
    end
  end
endmodule

// File: rtl/ets_chan.sv
module ets_chan #(
  parameter int DIV_W = 8,
  parameter int TS_W  = 40,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sig,
  input  logic [DIV_W-1:0] div,
  input  logic [TS_W-1:0]  ts,
  input  logic             pop,
  output logic [TS_W-1:0]  head,
  output logic             nonempty,
  output logic             ovf
);
  // two-flop synchronizer plus one history flop for edge detection
  logic s1, s2, s3;
  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= sig;
      s2 <= s1;
      s3 <= s2;
    end
  end
  logic rise;
  assign rise = s2 & ~s3;

  // edge decimator: report every Nth rising edge
  logic [DIV_W-1:0] cnt;
  logic [DIV_W:0]   nxt;
  logic             hit, fire;
  assign nxt  = {1'b0, cnt} + 1'b1;
  assign hit  = (div <= 1) || (nxt >= {1'b0, div});
  assign fire = rise & hit;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (rise) cnt <= hit ? '0 : nxt[DIV_W-1:0];
  end

  logic empty, full;
  ets_fifo #(.W(TS_W), .DEPTH(DEPTH)) u_q (
    .clk  (clk),
    .rst  (rst),
    .push (fire),
    .din  (ts),
    .pop  (pop),
    .head (head),
    .empty(empty),
    .full (full)
  );
  assign nonempty = ~empty;

  always_ff @(posedge clk) begin
    if (rst)              ovf <= 1'b0;
    else if (fire && full) ovf <= 1'b1;
  end
endmodule

// File: rtl/ets_arb.sv
module ets_arb #(
  parameter int NCH = 8,
  parameter int CW  = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] req,
  input  logic           adv,
  output logic [NCH-1:0] grant,
  output logic [CW-1:0]  gidx,
  output logic           any
);
  import ets_pkg::*;

  logic [CW-1:0] ptr;

  always_comb begin
    grant = '0;
    gidx  = '0;
    any   = 1'b0;
    for (int k = 0; k < NCH; k++) begin
      if (!any && req[(int'(ptr) + k) % NCH]) begin
        any = 1'b1;
        grant[(int'(ptr) + k) % NCH] = 1'b1;
        gidx = CW'((int'(ptr) + k) % NCH);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      ptr <= '0;
    else if (adv) ptr <= CW'(rr_next(int'(gidx), NCH));
  end
endmodule

// File: rtl/ets_top.sv
module ets_top #(
  parameter int NCH        = 8,
  parameter int DIV_W      = 8,
  parameter int TS_W       = 40,
  parameter int GRAN_SHIFT = 2,
  parameter int DEPTH      = 8,
  localparam int CW        = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NCH-1:0]       sig_in,
  input  logic [NCH*DIV_W-1:0] div_n,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [CW-1:0]        out_chan,
  output logic [TS_W-1:0]      out_ts,
  output logic [NCH-1:0]       ovf
);
  // shared timebase
  logic [TS_W-1:0] tb_q, ts_cap;
  always_ff @(posedge clk) begin
    if (rst) tb_q <= '0;
    else     tb_q <= tb_q + 1'b1;
  end

  generate
    if (GRAN_SHIFT > 0) begin : g_quant
      assign ts_cap = {tb_q[TS_W-1:GRAN_SHIFT], {GRAN_SHIFT{1'b0}}};
    end else begin : g_full
      assign ts_cap = tb_q;
    end
  endgenerate

  logic [NCH-1:0]  req, grant;
  logic [TS_W-1:0] head [NCH];
  logic [CW-1:0]   gidx;
  logic            any, take;

  assign take = any & (~out_valid | out_ready);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    ets_chan #(.DIV_W(DIV_W), .TS_W(TS_W), .DEPTH(DEPTH)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .sig     (sig_in[g]),
      .div     (div_n[g*DIV_W +: DIV_W]),
      .ts      (ts_cap),
      .pop     (grant[g] & take),
      .head    (head[g]),
      .nonempty(req[g]),
      .ovf     (ovf[g])
    );
  end

  ets_arb #(.NCH(NCH), .CW(CW)) u_arb (
    .clk  (clk),
    .rst  (rst),
    .req  (req),
    .adv  (take),
    .grant(grant),
    .gidx (gidx),
    .any  (any)
  );

  // registered output stage
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_chan  <= '0;
      out_ts    <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_chan  <= gidx;
      out_ts    <= head[gidx];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ets_chk.sv
module ets_chk #(
  parameter int NCH        = 8,
  parameter int TS_W       = 40,
  parameter int GRAN_SHIFT = 2,
  parameter int CW         = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            out_valid,
  input logic            out_ready,
  input logic [CW-1:0]   out_chan,
  input logic [TS_W-1:0] out_ts,
  input logic [NCH-1:0]  ovf,
  input logic [TS_W-1:0] tb_q
);
  AST_TB_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (tb_q == TS_W'($past(tb_q) + 1'b1))); // R1

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_ts) && $stable(out_chan))); // R9

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(ovf) & ~ovf) == '0)); // R8

  AST_CHAN_RANGE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (int'(out_chan) < NCH)); // R6

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!out_valid && (ovf == '0))); // R10

  generate
    if (GRAN_SHIFT > 0) begin : g_gran
      AST_TS_GRAN: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_ts[GRAN_SHIFT-1:0] == '0)); // R5
    end
  endgenerate
endmodule

bind ets_top ets_chk #(
  .NCH(NCH), .TS_W(TS_W), .GRAN_SHIFT(GRAN_SHIFT), .CW(CW)
) u_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_ready(out_ready),
  .out_chan(out_chan), .out_ts(out_ts), .ovf(ovf), .tb_q(tb_q)
);

// File: tb/tb_ets_top.sv
module tb_ets_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NCH = 3, DIV_W = 6, TS_W = 16, GS = 2, DEPTH = 4;
  localparam int CW = 2;
  localparam logic [TS_W-1:0] QMASK = ~TS_W'((1 << GS) - 1);
  // vector: {ready, channel mask[2:0]}
  localparam int NV = 10;
  localparam logic [3:0] VEC [NV] = '{4'b1111, 4'b1001, 4'b0010, 4'b0011, 4'b1100,
                                      4'b0111, 4'b1110, 4'b1010, 4'b0101, 4'b1111};

  logic clk = 1'b0, rst = 1'b1, rdy = 1'b0;
  logic [NCH-1:0] sig = '0;
  logic [NCH*DIV_W-1:0] divs = '0;
  logic out_valid;
  logic [CW-1:0] out_chan;
  logic [TS_W-1:0] out_ts;
  logic [NCH-1:0] ovf;

  always #2 clk = ~clk;

  ets_top #(.NCH(NCH), .DIV_W(DIV_W), .TS_W(TS_W), .GRAN_SHIFT(GS), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .sig_in(sig), .div_n(divs), .out_valid(out_valid),
    .out_ready(rdy), .out_chan(out_chan), .out_ts(out_ts), .ovf(ovf));

  logic [TS_W-1:0] cyc;
  always_ff @(posedge clk) cyc <= rst ? '0 : cyc + 1'b1;

  logic [TS_W-1:0] exq [NCH][64];
  int wr [NCH] = '{default: 0};
  int rd [NCH] = '{default: 0};
  int dcnt [NCH] = '{default: 0};
  int seq [256];
  int seq_n = 0;
  int chk_a = 0, err_a = 0, chk_b = 0, err_b = 0;
  bit wd_fail = 1'b0;

  // consumer-side checker: per-channel order and values (R2 R4 R5 R6)
  always begin : collect
    int c;
    @(negedge clk);
    #1;
    if (!rst && out_valid && rdy) begin
      c = int'(out_chan);
      seq[seq_n % 256] = c;
      seq_n++;
      chk_a++;
      if (c >= NCH || rd[c] >= wr[c]) begin
        err_a++;
        $display("FAIL R4 R6 unexpected entry chan=%0d ts=%0d expected none", c, out_ts);
      end else begin
        if (out_ts !== exq[c][rd[c] % 64]) begin
          err_a++;
          $display("FAIL R2 R5 R6 chan=%0d ts actual=%0d expected=%0d", c, out_ts, exq[c][rd[c] % 64]);
        end
        rd[c]++;
      end
    end
  end

  task automatic check(input string req, input bit ok, input int act, input int exp);
    chk_b++;
    if (!ok) begin
      err_b++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [NCH-1:0] m, input int hold, input bit store);
    logic [TS_W-1:0] v;
    int n;
    @(negedge clk);
    v = cyc;
    sig = sig | m;
    for (int c = 0; c < NCH; c++) begin
      if (m[c]) begin
        n = int'(divs[c*DIV_W +: DIV_W]);
        dcnt[c]++;
        if (n <= 1 || dcnt[c] >= n) begin
          dcnt[c] = 0;
          if (store) begin
            exq[c][wr[c] % 64] = TS_W'(v + 2) & QMASK;
            wr[c]++;
          end
        end
      end
    end
    repeat (hold) @(negedge clk);
    sig = sig & ~m;
    repeat (3) @(negedge clk);
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", chk_a + chk_b + (wd_fail ? 1 : 0),
             err_a + err_b + (wd_fail ? 1 : 0));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    wd_fail = 1'b1;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
    $finish;
  end

  initial begin : main
    int base;
    logic [TS_W-1:0] held;
    for (int c = 0; c < NCH; c++) divs[c*DIV_W +: DIV_W] = DIV_W'(1);
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 out_valid after reset", out_valid == 1'b0, int'(out_valid), 0);
    check("R10 ovf after reset", ovf == '0, int'(ovf), 0);

    // R7: rotating priority
    rdy = 1'b1;
    base = seq_n;
    pulse(3'b011, 3, 1'b1);
    repeat (4) @(negedge clk);
    pulse(3'b111, 3, 1'b1);
    repeat (8) @(negedge clk);
    check("R7 grant count", seq_n - base == 5, seq_n - base, 5);
    check("R7 first grant", seq[base % 256] == 0, seq[base % 256], 0);
    check("R7 second grant", seq[(base + 1) % 256] == 1, seq[(base + 1) % 256], 1);
    check("R7 rotate to 2", seq[(base + 2) % 256] == 2, seq[(base + 2) % 256], 2);
    check("R7 wrap to 0", seq[(base + 3) % 256] == 0, seq[(base + 3) % 256], 0);
    check("R7 then 1", seq[(base + 4) % 256] == 1, seq[(base + 4) % 256], 1);

    // vector walk: R2 R4 R5 R6 R9 with decimation 1, 3, 0
    divs[0*DIV_W +: DIV_W] = DIV_W'(1);
    divs[1*DIV_W +: DIV_W] = DIV_W'(3);
    divs[2*DIV_W +: DIV_W] = DIV_W'(0);
    for (int i = 0; i < NV; i++) begin
      rdy = VEC[i][3];
      pulse(VEC[i][2:0], 3, 1'b1);
    end
    rdy = 1'b1;
    repeat (30) @(negedge clk);

    // R3: long high level yields one entry only
    for (int c = 0; c < NCH; c++) divs[c*DIV_W +: DIV_W] = DIV_W'(1);
    base = seq_n;
    pulse(3'b100, 25, 1'b1);
    repeat (10) @(negedge clk);
    check("R3 one entry for long high", seq_n - base == 1, seq_n - base, 1);

    // R8 overflow and R9 hold
    rdy = 1'b0;
    for (int k = 0; k < DEPTH + 2; k++) pulse(3'b001, 3, k < DEPTH + 1);
    #1;
    check("R8 ovf set on channel 0 only", ovf == 3'b001, int'(ovf), 1);
    check("R9 valid held", out_valid == 1'b1, int'(out_valid), 1);
    held = out_ts;
    check("R9 oldest entry in output", out_ts == exq[0][rd[0] % 64], int'(out_ts), int'(exq[0][rd[0] % 64]));
    repeat (5) @(negedge clk);
    #1;
    check("R9 ts stable while stalled", out_ts == held, int'(out_ts), int'(held));
    @(negedge clk);
    rdy = 1'b1;
    repeat (30) @(negedge clk);
    check("R8 ovf sticky after drain", ovf == 3'b001, int'(ovf), 1);
    check("R8 no valid after drain", out_valid == 1'b0, int'(out_valid), 0);
    for (int c = 0; c < NCH; c++)
      check("R4 R6 all expected entries seen", rd[c] == wr[c], rd[c], wr[c]);
    report();
    $finish;
  end
endmodule